// File: doc/BRIEF.md
# Reply Timeout Encoder and Timer

This block turns a requested reply timeout, given in microseconds, into a compact hardware setting. The setting has two parts: a 2-bit multiplier code that selects a step size, and a 7-bit length that counts steps. The step size is chosen by range, from 8, 16, 32 or 64 microseconds. The length is the timeout divided by that step, rounded up and clamped to its field maximum.

The block also reports the setting that was active before the latest programming, decoded back into microseconds. A caller can then restore the old timeout later.

The same setting drives a reply timer. A start strobe launches a count of microsecond ticks. The timer raises a flag when the programmed number of steps has elapsed. A stop strobe, which stands for a reply arriving, ends the count without raising the flag.

Top module: `aux_reply_timer`

## Requirements
- R1: After reset, length_o is 69, mult_o is 0, prev_us_o is 552 and expired_o is low.
- R2: Programming a request of 0 us yields mult_o 0 and length_o 69.
- R3: For a nonzero request T, mult_o is chosen by range: 0 for T ≤ 1016, 1 for 1017..2032, 2 for 2033..4064 and 3 above 4064. The step is 8 << mult_o microseconds.
- R4: length_o equals T divided by the step, rounded up whenever a remainder exists; for example 1 gives 1, 9 gives 2, and 1017 gives 64.
- R5: length_o saturates at 127, for example for 8129 us and for 65535 us.
- R6: One cycle after a program strobe, prev_us_o equals the length of the replaced setting times its step in microseconds.
- R7: While prog_i is low, length_o and mult_o hold their values whatever tmo_us_i carries.
- R8: After a start strobe, expired_o rises at the edge that samples the tick number length × step, counting only ticks at edges after the start edge. It stays high until the next start.
- R9: A stop strobe ends a running count, and expired_o does not rise. This holds even when stop comes together with the final tick.
- R10: A start strobe clears expired_o and restarts the count from zero. A setting programmed while a count runs is used only from the next start.
- R11: When start and stop arrive in the same cycle, start wins and the count runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_i | input | 1 | Program strobe: encode tmo_us_i into the active setting |
| tmo_us_i | input | 16 | Requested timeout in microseconds |
| start_i | input | 1 | Launch the reply timer from the active setting |
| stop_i | input | 1 | Reply seen: end the running count |
| us_tick_i | input | 1 | One-cycle pulse per elapsed microsecond |
| length_o | output | 7 | Active length field |
| mult_o | output | 2 | Active multiplier code |
| prev_us_o | output | 13 | Replaced setting, decoded to microseconds |
| expired_o | output | 1 | Reply timeout flag |

## Verification
On every cycle, the embedded properties check the following:
- The flag can only rise out of a running count.
- The step counter stays below the latched length.
- A stop ends the run.
- A start leaves the timer running with the flag cleared.
- The active length is never zero.
- The setting holds when no program strobe is present.

Some behaviours only the bench scenarios can show. These are the exact range boundaries and the rounding, the saturation, and the decoded previous value. They also include the precise tick at which the flag rises, the stop on the final tick, and the rule that a setting changed mid-count takes effect only at the next start.

// File: rtl/aux_tmo_pkg.sv
package aux_tmo_pkg;

    parameter int unsigned TMO_LEN_W = 7;
    parameter int unsigned TMO_MUL_W = 2;

    typedef struct packed {
        logic [TMO_MUL_W-1:0] mul;
        logic [TMO_LEN_W-1:0] len;
    } tmo_field_t;

endpackage

// File: rtl/aux_tmo_encode.sv
module aux_tmo_encode
    import aux_tmo_pkg::*;
#(
    parameter int unsigned US_W       = 16,
    parameter int unsigned BASE_SHIFT = 3,
    parameter int unsigned DEF_LEN    = 69
) (
    input  logic [US_W-1:0] us_i,
    output tmo_field_t      fld_o
);
    localparam int unsigned LEN_MAX  = (1 << TMO_LEN_W) - 1;
    localparam int unsigned NUM_MUL  = 1 << TMO_MUL_W;
    localparam int unsigned SUM_W    = US_W + 1;

    logic [TMO_MUL_W-1:0] sel;
    logic [31:0]          thr;
    logic [SUM_W-1:0]     rounded;
    logic [SUM_W-1:0]     quot;
    int unsigned          shift;

    always_comb begin
        sel = TMO_MUL_W'(NUM_MUL - 1);
        thr = '0;
        // walk from the coarsest step down so the finest fitting step wins
        for (int m = NUM_MUL - 1; m >= 0; m--) begin
            thr = 32'(LEN_MAX) << (BASE_SHIFT + m);
            if (32'(us_i) <= thr) begin
                sel = TMO_MUL_W'(m);
            end
        end
        shift   = BASE_SHIFT + 32'(sel);
        rounded = {1'b0, us_i} + SUM_W'((32'd1 << shift) - 32'd1);
        quot    = rounded >> shift;
        if (us_i == '0) begin
            fld_o.mul = '0;
            fld_o.len = TMO_LEN_W'(DEF_LEN);
        end else begin
            fld_o.mul = sel;
            fld_o.len = (quot > SUM_W'(LEN_MAX)) ? TMO_LEN_W'(LEN_MAX)
                                                 : quot[TMO_LEN_W-1:0];
        end
    end

endmodule

// File: rtl/aux_tmo_decode.sv
module aux_tmo_decode
    import aux_tmo_pkg::*;
#(
    parameter int unsigned BASE_SHIFT = 3,
    parameter int unsigned DEF_LEN    = 69,
    parameter int unsigned MUL_CODES  = 4,
    parameter int unsigned OUT_W      = 13
) (
    input  tmo_field_t       fld_i,
    output logic [OUT_W-1:0] us_o
);
    always_comb begin
        if (32'(fld_i.mul) < MUL_CODES) begin
            us_o = OUT_W'(fld_i.len) << (BASE_SHIFT + 32'(fld_i.mul));
        end else begin
            // unknown code: report the default setting
            us_o = OUT_W'(DEF_LEN) << BASE_SHIFT;
        end
    end

endmodule

// File: rtl/aux_tmo_timer.sv
module aux_tmo_timer
    import aux_tmo_pkg::*;
#(
    parameter int unsigned BASE_SHIFT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       tick_i,
    input  tmo_field_t fld_i,
    output logic       expired_o
);
    localparam int unsigned SUB_W = BASE_SHIFT + (1 << TMO_MUL_W) - 1;

    typedef struct packed {
        logic                 run;
        logic                 expired;
        tmo_field_t           fld;
        logic [SUB_W-1:0]     sub;
        logic [TMO_LEN_W-1:0] units;
    } tmr_state_t;

    tmr_state_t d, q;
    logic [SUB_W-1:0]     unit_last;
    logic [TMO_LEN_W-1:0] units_nx;

    always_comb begin
        d         = q;
        unit_last = SUB_W'((32'd1 << (BASE_SHIFT + 32'(q.fld.mul))) - 32'd1);
        units_nx  = q.units + TMO_LEN_W'(1);
        if (start_i) begin
            d.run     = 1'b1;
            d.expired = 1'b0;
            d.fld     = fld_i;
            d.sub     = '0;
            d.units   = '0;
        end else if (stop_i) begin
            d.run = 1'b0;
        end else if (q.run && tick_i) begin
            if (q.sub == unit_last) begin
                d.sub   = '0;
                d.units = units_nx;
                if (units_nx == q.fld.len) begin
                    d.run     = 1'b0;
                    d.expired = 1'b1;
                end
            end else begin
                d.sub = q.sub + SUB_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign expired_o = q.expired;

    // R8
    expire_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.expired) |-> $past(q.run));

    // R8
    unit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.run |-> (q.units < q.fld.len));

    // R9
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (!q.run && !$rose(q.expired)));

    // R10
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (q.run && !q.expired));

endmodule

// File: rtl/aux_reply_timer.sv
module aux_reply_timer
    import aux_tmo_pkg::*;
#(
    parameter int unsigned US_W       = 16,
    parameter int unsigned BASE_SHIFT = 3,
    parameter int unsigned DEF_LEN    = 69,
    parameter int unsigned MUL_CODES  = 4,
    localparam int unsigned PREV_W    = TMO_LEN_W + BASE_SHIFT + (1 << TMO_MUL_W) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prog_i,
    input  logic [US_W-1:0]      tmo_us_i,
    input  logic                 start_i,
    input  logic                 stop_i,
    input  logic                 us_tick_i,
    output logic [TMO_LEN_W-1:0] length_o,
    output logic [TMO_MUL_W-1:0] mult_o,
    output logic [PREV_W-1:0]    prev_us_o,
    output logic                 expired_o
);
    typedef struct packed {
        tmo_field_t cur;
        tmo_field_t prev;
    } cfg_state_t;

    cfg_state_t d, q;
    tmo_field_t enc_fld;
    tmo_field_t def_fld;

    assign def_fld = '{mul: '0, len: TMO_LEN_W'(DEF_LEN)};

    aux_tmo_encode #(
        .US_W      (US_W),
        .BASE_SHIFT(BASE_SHIFT),
        .DEF_LEN   (DEF_LEN)
    ) i_encode (
        .us_i (tmo_us_i),
        .fld_o(enc_fld)
    );

    always_comb begin
        d = q;
        if (prog_i) begin
            d.prev = q.cur;
            d.cur  = enc_fld;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cur: def_fld, prev: def_fld};
        end else begin
            q <= d;
        end
    end

    aux_tmo_decode #(
        .BASE_SHIFT(BASE_SHIFT),
        .DEF_LEN   (DEF_LEN),
        .MUL_CODES (MUL_CODES),
        .OUT_W     (PREV_W)
    ) i_decode (
        .fld_i(q.prev),
        .us_o (prev_us_o)
    );

    aux_tmo_timer #(
        .BASE_SHIFT(BASE_SHIFT)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .tick_i   (us_tick_i),
        .fld_i    (q.cur),
        .expired_o(expired_o)
    );

    assign length_o = q.cur.len;
    assign mult_o   = q.cur.mul;

    // R4
    nonzero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        length_o != '0);

    // R7
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_i |=> ($stable(length_o) && $stable(mult_o)));

endmodule

// File: tb/test_aux_reply_timer.sv
module test_aux_reply_timer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        prog_i, start_i, stop_i, us_tick_i;
    logic [15:0] tmo_us_i;
    logic [6:0]  length_o;
    logic [1:0]  mult_o;
    logic [12:0] prev_us_o;
    logic        expired_o;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    int m_len, m_mul, m_plen, m_pmul, m_cnt, m_limit;
    bit m_run, m_exp;

    always #4 clk = ~clk;

    aux_reply_timer i_aux_reply_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_i   (prog_i),
        .tmo_us_i (tmo_us_i),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .us_tick_i(us_tick_i),
        .length_o (length_o),
        .mult_o   (mult_o),
        .prev_us_o(prev_us_o),
        .expired_o(expired_o)
    );

    function automatic void ref_enc(input int t, output int l, output int m);
        int u;
        if (t == 0) begin
            l = 69; m = 0;
        end else begin
            if (t <= 1016)      begin m = 0; u = 8;  end
            else if (t <= 2032) begin m = 1; u = 16; end
            else if (t <= 4064) begin m = 2; u = 32; end
            else                begin m = 3; u = 64; end
            l = t / u;
            if (t % u != 0) l = l + 1;
            if (l > 127) l = 127;
        end
    endfunction

    task automatic chk(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_len = 69; m_mul = 0; m_plen = 69; m_pmul = 0;
            m_run = 0; m_exp = 0; m_cnt = 0; m_limit = 0;
        end else begin
            if (start_i) begin
                m_run = 1; m_exp = 0; m_cnt = 0;
                m_limit = m_len * (8 << m_mul);
            end else if (stop_i) begin
                m_run = 0;
            end else if (m_run && us_tick_i) begin
                m_cnt++;
                if (m_cnt == m_limit) begin
                    m_exp = 1; m_run = 0;
                end
            end
            if (prog_i) begin
                int l, m;
                m_plen = m_len; m_pmul = m_mul;
                ref_enc(int'(tmo_us_i), l, m);
                m_len = l; m_mul = m;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, int'(length_o), m_len, "model length");
            chk(cur_req, int'(mult_o), m_mul, "model mult");
            chk(cur_req, int'(prev_us_o), m_plen * (8 << m_pmul), "model prev");
            chk(cur_req, int'(expired_o), int'(m_exp), "model expired");
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_prog(input int t, input int el, input int em, input int ep, input string req);
        cur_req = req;
        @(negedge clk);
        prog_i = 1'b1; tmo_us_i = t[15:0];
        @(negedge clk);
        prog_i = 1'b0;
        chk(req, int'(length_o), el, "length");
        chk(req, int'(mult_o), em, "mult");
        chk("R6", int'(prev_us_o), ep, "prev us");
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk); us_tick_i = 1'b1;
            @(negedge clk); us_tick_i = 1'b0;
        end
    endtask

    task automatic do_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; prog_i = 1'b0; start_i = 1'b0; stop_i = 1'b0;
        us_tick_i = 1'b0; tmo_us_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", int'(length_o), 69, "reset length");
        chk("R1", int'(mult_o), 0, "reset mult");
        chk("R1", int'(prev_us_o), 552, "reset prev");
        chk("R1", int'(expired_o), 0, "reset expired");

        do_prog(0,     69,  0, 552,  "R2");
        do_prog(1016,  127, 0, 552,  "R3");
        do_prog(1017,  64,  1, 1016, "R3");
        do_prog(2032,  127, 1, 1024, "R3");
        do_prog(2033,  64,  2, 2032, "R3");
        do_prog(4064,  127, 2, 2048, "R3");
        do_prog(4065,  64,  3, 4064, "R4");
        do_prog(8129,  127, 3, 4096, "R5");
        do_prog(65535, 127, 3, 8128, "R5");
        do_prog(9,     2,   0, 8128, "R4");
        do_prog(8,     1,   0, 16,   "R4");
        do_prog(1,     1,   0, 8,    "R4");

        cur_req = "R7";
        @(negedge clk); tmo_us_i = 16'd500;
        repeat (3) @(negedge clk);
        chk("R7", int'(length_o), 1, "held length");
        chk("R7", int'(mult_o), 0, "held mult");

        do_prog(16, 2, 0, 8, "R8");
        cur_req = "R8";
        do_start();
        ticks(15);
        chk("R8", int'(expired_o), 0, "before last tick");
        ticks(1);
        chk("R8", int'(expired_o), 1, "on last tick");
        ticks(3);
        chk("R8", int'(expired_o), 1, "flag held");

        cur_req = "R9";
        do_start();
        ticks(10);
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        ticks(20);
        chk("R9", int'(expired_o), 0, "after stop");
        do_start();
        ticks(15);
        @(negedge clk); stop_i = 1'b1; us_tick_i = 1'b1;
        @(negedge clk); stop_i = 1'b0; us_tick_i = 1'b0;
        chk("R9", int'(expired_o), 0, "stop with last tick");
        ticks(5);
        chk("R9", int'(expired_o), 0, "stop with last tick later");

        cur_req = "R10";
        do_start();
        ticks(10);
        do_prog(8, 1, 0, 16, "R10");
        cur_req = "R10";
        ticks(5);
        chk("R10", int'(expired_o), 0, "old length still running");
        ticks(1);
        chk("R10", int'(expired_o), 1, "old length expiry");
        do_start();
        chk("R10", int'(expired_o), 0, "start clears flag");
        ticks(7);
        chk("R10", int'(expired_o), 0, "new length pending");
        ticks(1);
        chk("R10", int'(expired_o), 1, "new length expiry");
        do_prog(16, 2, 0, 8, "R10");
        cur_req = "R10";
        do_start();
        ticks(10);
        do_start();
        ticks(10);
        chk("R10", int'(expired_o), 0, "restart count");
        ticks(6);
        chk("R10", int'(expired_o), 1, "restart expiry");

        cur_req = "R11";
        @(negedge clk); start_i = 1'b1; stop_i = 1'b1;
        @(negedge clk); start_i = 1'b0; stop_i = 1'b0;
        chk("R11", int'(expired_o), 0, "start over stop");
        ticks(15);
        chk("R11", int'(expired_o), 0, "start over stop running");
        ticks(1);
        chk("R11", int'(expired_o), 1, "start over stop expiry");

        do_prog(1017, 64, 1, 16, "R8");
        cur_req = "R8";
        do_start();
        ticks(1023);
        chk("R8", int'(expired_o), 0, "16 us steps pending");
        ticks(1);
        chk("R8", int'(expired_o), 1, "16 us steps expiry");

        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule